// File: doc/BRIEF.md
# Burst-Triggered Shared Comparator Scheduler

This block time-shares a single analog comparator between an automatic power control (APC) loop and three fast alarms in a burst-mode optical transmitter. A rising edge on the burst-enable input starts a countdown to the first comparator sample. After that sample, strobes repeat at a fixed period. A 4-bit update-rate code, captured at the burst edge, sets both the first-sample delay and the repeat period. Each strobe takes the next position in an eight-slot rotation. That position decides which input and reference the comparator is pointed at, and it decides what the block does with the comparator's answer.

Slot 0 checks the bias monitor against the bias ceiling. Slot 1 checks transmit power against one of two thresholds. The threshold is the upper one when the most recent APC reading was above the set point, and the lower one otherwise. Slots 2 to 7 feed the APC loop, and each of them can issue a one-cycle bias increase or bias decrease request. The burst-enable input is asynchronous and is synchronized inside the block. While it is low, the power alarms and the APC history are held, but the bias alarm keeps being sampled. The block runs from a 20 MHz clock, so one cycle is 50 ns.

Top module: `burst_cmp_sched`

## Requirements
- R1: `burst_en_i` passes through two synchronizer flops. The first `sample_o` pulse of a burst appears in the cycle after the (2 + t_first)-th rising clock edge that follows the rise of `burst_en_i`.
- R2: After the first pulse, `sample_o` pulses for one cycle every t_rep cycles. It keeps doing so whether burst enable is high or low, until the next burst rising edge.
- R3: Rate code values 0 to 9 give t_first of 7, 11, 15, 19, 27, 31, 35, 43, 59, 63 cycles and t_rep of 16, 24, 32, 40, 56, 64, 72, 88, 120, 128 cycles. Codes 10 to 15 behave exactly like code 9.
- R4: The rate code is captured only on a burst rising edge. A change while a burst is running leaves the strobe spacing unchanged.
- R5: `slot_o` shows the slot of the current strobe. It is 0 for the first strobe after a rising edge and advances by one after each strobe, wrapping from 7 to 0. A new rising edge restarts the countdown and returns `slot_o` to 0. The encoding of `sel_o` is: 0 = bias monitor vs bias ceiling (slot 0), 1 = power vs upper threshold, 2 = power vs lower threshold, 3 = power vs APC set point (slots 2 to 7).
- R6: In slot 1, `sel_o` is 1 if the last recorded APC result was "above" and 2 otherwise. After reset, the recorded result is "below".
- R7: At a slot-1 strobe with burst high, the upper check sets `txp_hi_alarm_o` to `cmp_above_i`, and the lower check sets `txp_lo_alarm_o` to the inverse of `cmp_above_i`. The other power alarm keeps its value. The update is visible in the cycle after the strobe.
- R8: While synchronized burst enable is low, both power alarms and the recorded APC result keep their values.
- R9: At every slot-0 strobe, `bias_hi_alarm_o` takes the value of `cmp_above_i` in the following cycle, regardless of burst enable.
- R10: At an APC-slot strobe with burst high, the next cycle carries a one-cycle `bias_dn_o` pulse if `cmp_above_i` is 1, or a one-cycle `bias_up_o` pulse if it is 0, and the result is recorded. No request is made while burst is low, and the two requests are never high together.
- R11: After reset, all outputs are 0 and no strobe occurs until a burst rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_en_i | input | 1 | Asynchronous burst enable |
| rate_code_i | input | 4 | Update-rate code, captured at each burst rising edge |
| cmp_above_i | input | 1 | Comparator result: selected input above selected reference |
| sample_o | output | 1 | One-cycle comparator sample strobe |
| slot_o | output | 3 | Slot index of the current strobe |
| sel_o | output | 2 | Comparator input/reference selection |
| bias_up_o | output | 1 | One-cycle bias increase request |
| bias_dn_o | output | 1 | One-cycle bias decrease request |
| txp_hi_alarm_o | output | 1 | Transmit power high alarm |
| txp_lo_alarm_o | output | 1 | Transmit power low alarm |
| bias_hi_alarm_o | output | 1 | Bias high alarm |

## Verification
The properties assume that `cmp_above_i` has settled for the current `sel_o` in the strobe cycle, which means the comparator path is treated as combinational within one cycle. They also assume that burst enable stays at each level long enough to pass the synchronizer, so every rise is seen as one clean edge. The stimulus drives the comparator from a four-level power model and a bias flag through a continuous function of `sel_o`. It changes burst enable and the rate code only on falling clock edges, several cycles away from any strobe. Before each new rise, it holds burst enable low for at least four cycles.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;

    typedef enum logic [1:0] {
        SEL_BIAS_CEIL = 2'd0,
        SEL_PWR_UPPER = 2'd1,
        SEL_PWR_LOWER = 2'd2,
        SEL_APC_POINT = 2'd3
    } cmp_sel_e;

    localparam int unsigned MAX_MULT = 16;

    // Repeat period in units; first-sample delay is half a period less one cycle.
    function automatic int unsigned rate_mult(input logic [3:0] code);
        case (code)
            4'd0:    rate_mult = 2;
            4'd1:    rate_mult = 3;
            4'd2:    rate_mult = 4;
            4'd3:    rate_mult = 5;
            4'd4:    rate_mult = 7;
            4'd5:    rate_mult = 8;
            4'd6:    rate_mult = 9;
            4'd7:    rate_mult = 11;
            4'd8:    rate_mult = 15;
            default: rate_mult = MAX_MULT;
        endcase
    endfunction

endpackage

// File: rtl/bsched_sync.sv
module bsched_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level_o = sh_q[STAGES-1];
    assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/bsched_timer.sv
module bsched_timer
    import burst_sched_pkg::*;
#(
    parameter int UNIT_CYC  = 8,
    parameter int NUM_SLOTS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rise_i,
    input  logic [3:0]                   code_i,
    output logic                         strobe_o,
    output logic [$clog2(NUM_SLOTS)-1:0] slot_o
);
    localparam int CNT_W  = $clog2(MAX_MULT * UNIT_CYC + 1);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    typedef struct packed {
        logic              active;
        logic [3:0]        code;
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
    } tmr_s;

    tmr_s st_d, st_q;
    logic strobe_c;

    always_comb begin
        st_d     = st_q;
        strobe_c = st_q.active && (st_q.cnt == '0) && !rise_i;
        if (rise_i) begin
            st_d.active = 1'b1;
            st_d.code   = code_i;
            st_d.cnt    = CNT_W'((rate_mult(code_i) * UNIT_CYC) / 2 - 2);
            st_d.slot   = '0;
        end else if (strobe_c) begin
            st_d.cnt  = CNT_W'(rate_mult(st_q.code) * UNIT_CYC - 1);
            st_d.slot = (st_q.slot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : st_q.slot + 1'b1;
        end else if (st_q.active) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o = strobe_c;
    assign slot_o   = st_q.slot;
endmodule

// File: rtl/bsched_decide.sv
module bsched_decide
    import burst_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         strobe_i,
    input  logic [$clog2(NUM_SLOTS)-1:0] slot_i,
    input  logic                         burst_i,
    input  logic                         cmp_above_i,
    output cmp_sel_e                     sel_o,
    output logic                         bias_up_o,
    output logic                         bias_dn_o,
    output logic                         pwr_hi_o,
    output logic                         pwr_lo_o,
    output logic                         bias_hi_o
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam logic [SLOT_W-1:0] SLOT_BIAS = SLOT_W'(0);
    localparam logic [SLOT_W-1:0] SLOT_PWR  = SLOT_W'(1);

    typedef struct packed {
        logic last_above;
        logic up;
        logic dn;
        logic pwr_hi;
        logic pwr_lo;
        logic bias_hi;
    } dec_s;

    dec_s dc_d, dc_q;
    cmp_sel_e sel_c;

    always_comb begin
        if (slot_i == SLOT_BIAS)     sel_c = SEL_BIAS_CEIL;
        else if (slot_i == SLOT_PWR) sel_c = dc_q.last_above ? SEL_PWR_UPPER : SEL_PWR_LOWER;
        else                         sel_c = SEL_APC_POINT;

        dc_d    = dc_q;
        dc_d.up = 1'b0;
        dc_d.dn = 1'b0;
        if (strobe_i) begin
            if (slot_i == SLOT_BIAS) begin
                dc_d.bias_hi = cmp_above_i;
            end else if (slot_i == SLOT_PWR) begin
                if (burst_i) begin
                    if (dc_q.last_above) dc_d.pwr_hi = cmp_above_i;
                    else                 dc_d.pwr_lo = ~cmp_above_i;
                end
            end else if (burst_i) begin
                dc_d.last_above = cmp_above_i;
                dc_d.up         = ~cmp_above_i;
                dc_d.dn         = cmp_above_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dc_q <= '0;
        else        dc_q <= dc_d;
    end

    assign sel_o     = sel_c;
    assign bias_up_o = dc_q.up;
    assign bias_dn_o = dc_q.dn;
    assign pwr_hi_o  = dc_q.pwr_hi;
    assign pwr_lo_o  = dc_q.pwr_lo;
    assign bias_hi_o = dc_q.bias_hi;
endmodule

// File: rtl/burst_cmp_sched.sv
module burst_cmp_sched
    import burst_sched_pkg::*;
#(
    parameter int UNIT_CYC    = 8,
    parameter int NUM_SLOTS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         burst_en_i,
    input  logic [3:0]                   rate_code_i,
    input  logic                         cmp_above_i,
    output logic                         sample_o,
    output logic [$clog2(NUM_SLOTS)-1:0] slot_o,
    output logic [1:0]                   sel_o,
    output logic                         bias_up_o,
    output logic                         bias_dn_o,
    output logic                         txp_hi_alarm_o,
    output logic                         txp_lo_alarm_o,
    output logic                         bias_hi_alarm_o
);
    logic     burst_lvl_w;
    logic     rise_w;
    logic     strobe_w;
    cmp_sel_e sel_w;

    bsched_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (burst_en_i),
        .level_o (burst_lvl_w),
        .rise_o  (rise_w)
    );

    bsched_timer #(.UNIT_CYC(UNIT_CYC), .NUM_SLOTS(NUM_SLOTS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise_w),
        .code_i   (rate_code_i),
        .strobe_o (strobe_w),
        .slot_o   (slot_o)
    );

    bsched_decide #(.NUM_SLOTS(NUM_SLOTS)) u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe_w),
        .slot_i      (slot_o),
        .burst_i     (burst_lvl_w),
        .cmp_above_i (cmp_above_i),
        .sel_o       (sel_w),
        .bias_up_o   (bias_up_o),
        .bias_dn_o   (bias_dn_o),
        .pwr_hi_o    (txp_hi_alarm_o),
        .pwr_lo_o    (txp_lo_alarm_o),
        .bias_hi_o   (bias_hi_alarm_o)
    );

    assign sample_o = strobe_w;
    assign sel_o    = sel_w;
endmodule

// File: rtl/burst_cmp_sched_chk.sv
module burst_cmp_sched_chk
    import burst_sched_pkg::*;
#(
    parameter int UNIT_CYC  = 8,
    parameter int NUM_SLOTS = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rise,
    input logic                         burst_lvl,
    input logic [3:0]                   rate_code,
    input logic                         sample,
    input logic [$clog2(NUM_SLOTS)-1:0] slot,
    input logic [1:0]                   sel,
    input logic                         up,
    input logic                         dn,
    input logic                         pwr_hi,
    input logic                         pwr_lo,
    input logic                         bias_hi
);
    logic [3:0]  code_q;
    logic [15:0] gap_q;
    logic        first_q;
    int          rep_w;

    assign rep_w = int'(rate_mult(code_q)) * UNIT_CYC;

    // Independent window counter: cycles since the last strobe or burst edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            gap_q   <= '0;
            first_q <= 1'b0;
        end else begin
            if (rise) begin
                code_q  <= rate_code;
                first_q <= 1'b1;
            end else if (sample) begin
                first_q <= 1'b0;
            end
            gap_q <= (rise || sample) ? 16'd1 : gap_q + 16'd1;
        end
    end

    assert_first_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && first_q) |-> (int'(gap_q) == rep_w / 2 - 1));

    assert_repeat_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !first_q) |-> (int'(gap_q) == rep_w));

    assert_restart_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (slot == '0 && !sample));

    assert_sel_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot > 1) |-> (sel == 2'd3));

    assert_pwr_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 1) |-> (sel == 2'd1 || sel == 2'd2));

    assert_pwr_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pwr_hi) || !$stable(pwr_lo)) |-> $past(sample && slot == 1 && burst_lvl));

    assert_pwr_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_lvl |=> ($stable(pwr_hi) && $stable(pwr_lo)));

    assert_bias_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bias_hi) |-> $past(sample && slot == 0));

    assert_req_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (up || dn) |-> $past(sample && slot > 1 && burst_lvl));

    assert_req_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));
endmodule

bind burst_cmp_sched burst_cmp_sched_chk #(.UNIT_CYC(UNIT_CYC), .NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rise_w),
    .burst_lvl (burst_lvl_w),
    .rate_code (rate_code_i),
    .sample    (sample_o),
    .slot      (slot_o),
    .sel       (sel_o),
    .up        (bias_up_o),
    .dn        (bias_dn_o),
    .pwr_hi    (txp_hi_alarm_o),
    .pwr_lo    (txp_lo_alarm_o),
    .bias_hi   (bias_hi_alarm_o)
);

// File: tb/burst_cmp_sched_test.sv
module burst_cmp_sched_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       burst_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       cmp_above;
    logic       sample;
    logic [2:0] slot;
    logic [1:0] sel;
    logic       up, dn, thi, tlo, bhi;

    int pwr = 0;        // 0 below low thr, 1 low..setpoint, 2 setpoint..high, 3 above high
    bit bias_over = 1'b0;

    always #2 clk = ~clk;

    // Comparator model driven from the selection
    assign cmp_above = (sel == 2'd0) ? bias_over :
                       (sel == 2'd1) ? (pwr == 3) :
                       (sel == 2'd2) ? (pwr >= 1) : (pwr >= 2);

    burst_cmp_sched uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .burst_en_i      (burst_en),
        .rate_code_i     (rate_code),
        .cmp_above_i     (cmp_above),
        .sample_o        (sample),
        .slot_o          (slot),
        .sel_o           (sel),
        .bias_up_o       (up),
        .bias_dn_o       (dn),
        .txp_hi_alarm_o  (thi),
        .txp_lo_alarm_o  (tlo),
        .bias_hi_alarm_o (bhi)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int t_first(input int code);
        int c = (code > 9) ? 9 : code;
        case (c)
            0: return 7;   1: return 11;  2: return 15;  3: return 19;
            4: return 27;  5: return 31;  6: return 35;  7: return 43;
            8: return 59;  default: return 63;
        endcase
    endfunction

    function automatic int t_rep(input int code);
        int c = (code > 9) ? 9 : code;
        case (c)
            0: return 16;  1: return 24;  2: return 32;  3: return 40;
            4: return 56;  5: return 64;  6: return 72;  7: return 88;
            8: return 120; default: return 128;
        endcase
    endfunction

    typedef struct {
        int cyc; int slot; int sel;
        bit up; bit dn; bit thi; bit tlo; bit bhi;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    bit    pend = 1'b0;

    // Reference model state
    int m_next = 0, m_rep = 0, m_slot = 0;
    bit m_lvl = 1'b0, m_last = 1'b0, m_thi = 1'b0, m_tlo = 1'b0, m_bhi = 1'b0;

    // Monitor: compares strobes and their effects with queued expectations
    always @(negedge clk) begin
        if (pend) begin
            chk("R7/R10 bias_up", int'(up), int'(cur.up));
            chk("R10 bias_dn", int'(dn), int'(cur.dn));
            chk("R7/R8 txp_hi", int'(thi), int'(cur.thi));
            chk("R7/R8 txp_lo", int'(tlo), int'(cur.tlo));
            chk("R9 bias_hi", int'(bhi), int'(cur.bhi));
            pend = 1'b0;
        end
        if (sample && exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            chk("R1/R2/R3 strobe cycle", cyc, cur.cyc);
            chk("R5 slot", int'(slot), cur.slot);
            chk("R5/R6 sel", int'(sel), cur.sel);
            pend = 1'b1;
        end
    end

    task automatic start_burst(input int code);
        if (burst_en) begin
            burst_en = 1'b0;
            repeat (4) @(negedge clk);
        end
        burst_en  = 1'b1;
        rate_code = 4'(code);
        m_next    = cyc + 2 + t_first(code);
        m_rep     = t_rep(code);
        m_slot    = 0;
        m_lvl     = 1'b1;
    endtask

    task automatic expect_strobes(input int n);
        for (int i = 0; i < n; i++) begin
            item_t it;
            int    s;
            bit    c;
            it.cyc  = m_next;
            it.slot = m_slot;
            s = (m_slot == 0) ? 0 : (m_slot == 1) ? (m_last ? 1 : 2) : 3;
            it.sel = s;
            c = (s == 0) ? bias_over : (s == 1) ? (pwr == 3) : (s == 2) ? (pwr >= 1) : (pwr >= 2);
            it.up = 1'b0;
            it.dn = 1'b0;
            if (m_slot == 0) m_bhi = c;
            else if (m_slot == 1) begin
                if (m_lvl) begin
                    if (m_last) m_thi = c;
                    else        m_tlo = !c;
                end
            end else if (m_lvl) begin
                m_last = c;
                it.up  = !c;
                it.dn  = c;
            end
            it.thi = m_thi;
            it.tlo = m_tlo;
            it.bhi = m_bhi;
            exp_q.push_back(it);
            m_next += m_rep;
            m_slot = (m_slot + 1) % 8;
        end
        wait (exp_q.size() == 0 && !pend);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 sample", int'(sample), 0);
        chk("R11 bias_up", int'(up), 0);
        chk("R11 bias_dn", int'(dn), 0);
        chk("R11 alarms", int'({thi, tlo, bhi}), 0);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sample) seen++;
        end
        chk("R11 no strobe before burst", seen, 0);

        // R1 R2 R5 R6 R7 R9 R10: code 0, power above high, bias over
        pwr = 3; bias_over = 1'b1;
        start_burst(0);
        expect_strobes(10);

        // R4: code change mid-burst ignored; power below low threshold
        rate_code = 4'd5;
        pwr = 0;
        expect_strobes(8);

        // R8 R9 R2: burst low, strobes continue, power alarms frozen
        burst_en = 1'b0; m_lvl = 1'b0;
        pwr = 3; bias_over = 1'b0;
        expect_strobes(9);

        // R3: code 12 behaves like code 9
        pwr = 2; bias_over = 1'b1;
        start_burst(12);
        expect_strobes(9);

        // R5: restart during a pending first-sample countdown
        start_burst(4);
        repeat (10) @(negedge clk);
        pwr = 1;
        start_burst(3);
        expect_strobes(3);

        // R3: another table entry
        start_burst(8);
        expect_strobes(2);

        finish_run();
    end
endmodule